// File: doc/BRIEF.md
# Bidirectional Blit Address Generator

This block produces the byte addresses that a rectangle copy engine needs when it moves a block of pixels from one place on a screen to another. Each pixel coordinate is turned into a byte offset by multiplying it by the bytes per pixel. Rows are laid out one line pitch apart. A single start strobe captures the source and destination corners, the rectangle size, the pixel depth, the pitch and a two-bit direction code. From the next cycle on, the block emits one source/destination address pair per cycle until the rectangle is covered. It then raises a one-cycle done pulse.

Copies whose source and destination overlap must read each byte before it is overwritten. For this the traversal can run in either horizontal and either vertical direction. When a direction is decreasing, the first address moves to the far edge of the rectangle, down to the last byte of the last pixel, and the walk proceeds backwards. Moving the data and combining pixels are left to the surrounding engine.

Top module: `blitAddrGen`

## Requirements
- R1: While reset is held and after it is released, addrValid and done are low until a start is accepted.
- R2: A start seen while idle captures all inputs. The first address pair appears in the following cycle. With direction code 0 it equals y*pitch + x*bpp for both source and destination.
- R3: Direction bit 0 set (right-to-left) makes each row begin at x*bpp + width*bpp - 1 and step down by one byte per pair. With the bit clear, each row begins at x*bpp and steps up by one byte.
- R4: Direction bit 1 set (bottom-to-top) makes the first row base (y + height - 1)*pitch, and each following row lies one pitch lower. With the bit clear, the first row base is y*pitch and rows advance by one pitch.
- R5: The pitch input carries the line pitch in bytes minus one.
- R6: Each row yields width*bpp consecutive byte addresses. The next row restarts from the same horizontal start byte, one pitch away in the selected vertical direction.
- R7: An operation emits exactly width*bpp*height pairs, on consecutive cycles, with no gap.
- R8: done is high for exactly one cycle, in the cycle right after the last pair, and never together with addrValid.
- R9: If width, height or bpp is zero, done rises in the cycle after the start and no pair is emitted.
- R10: A start asserted while an operation is running is ignored. The running stream continues unchanged and produces a single done.
- R11: Source and destination share direction and pitch, so from one pair to the next both addresses change by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| srcX | input | COORD_W | Source left pixel column |
| srcY | input | COORD_W | Source top pixel row |
| dstX | input | COORD_W | Destination left pixel column |
| dstY | input | COORD_W | Destination top pixel row |
| width | input | COORD_W | Rectangle width in pixels |
| height | input | COORD_W | Rectangle height in rows |
| bpp | input | BPP_W | Bytes per pixel |
| pitchM1 | input | PITCH_W | Line pitch in bytes minus one |
| dir | input | 2 | bit0: right-to-left, bit1: bottom-to-top |
| addrValid | output | 1 | An address pair is presented this cycle |
| srcAddr | output | ADDR_W | Source byte address |
| dstAddr | output | ADDR_W | Destination byte address |
| done | output | 1 | One-cycle pulse after the operation ends |

## Verification
The properties assume that start is driven from a clean register. They also assume that the geometry inputs are stable at the sampling edge of an accepted start. Beyond that cycle they may change freely, because the block keeps its own copies. The bench drives every input on the falling clock edge and keeps addresses well inside ADDR_W, so its plain integer reference never wraps. The bench also changes the geometry in the middle of a stream, together with a second start, to show that the captured copy is what counts.

// File: rtl/blit_pkg.sv
package blit_pkg;
  // Strobes issued by the sequencer to the address datapath
  typedef struct packed {
    logic load;     // capture start addresses and direction
    logic stepCol;  // advance one byte along the current row
    logic stepRow;  // return to row start and move one pitch
  } blitStrobe_t;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} blitState_t;
endpackage

// File: rtl/blit_chan.sv
module blit_chan import blit_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int BPP_W   = 3,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  blitStrobe_t        strb,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [BPP_W-1:0]   bpp,
  input  logic [PITCH_W:0]   pitch,
  input  logic               decX,
  input  logic               decY,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] xBytes, spanBytes, colStart, yEff, rowBase, startAddr;
  logic [ADDR_W-1:0] pitchA, rowStart, curAddr, nextRow;

  always_comb begin
    pitchA    = ADDR_W'(pitch);
    xBytes    = ADDR_W'(posX) * ADDR_W'(bpp);
    spanBytes = ADDR_W'(width) * ADDR_W'(bpp);
    colStart  = decX ? (xBytes + spanBytes - ADDR_W'(1)) : xBytes;
    yEff      = decY ? (ADDR_W'(posY) + ADDR_W'(height) - ADDR_W'(1)) : ADDR_W'(posY);
    rowBase   = yEff * pitchA;
    startAddr = rowBase + colStart;
    nextRow   = decY ? (rowStart - pitchA) : (rowStart + pitchA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowStart <= '0;
      curAddr  <= '0;
    end else if (strb.load) begin
      rowStart <= startAddr;
      curAddr  <= startAddr;
    end else if (strb.stepRow) begin
      rowStart <= nextRow;
      curAddr  <= nextRow;
    end else if (strb.stepCol) begin
      curAddr  <= decX ? (curAddr - ADDR_W'(1)) : (curAddr + ADDR_W'(1));
    end
  end

  assign addr = curAddr;
endmodule

// File: rtl/blit_dp.sv
module blit_dp import blit_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int BPP_W   = 3,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  blitStrobe_t        strb,
  input  logic [COORD_W-1:0] srcX,
  input  logic [COORD_W-1:0] srcY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [BPP_W-1:0]   bpp,
  input  logic [PITCH_W-1:0] pitchM1,
  input  logic [1:0]         dir,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr
);
  localparam int NCHAN = 2;

  logic [1:0]         dirR, dirNow;
  logic [PITCH_W:0]   pitchR, pitchNow;
  logic [COORD_W-1:0] chX [NCHAN];
  logic [COORD_W-1:0] chY [NCHAN];
  logic [ADDR_W-1:0]  chAddr [NCHAN];

  // Live values feed the start calculation, held copies feed the stepping
  always_comb begin
    dirNow   = strb.load ? dir : dirR;
    pitchNow = strb.load ? ({1'b0, pitchM1} + (PITCH_W+1)'(1)) : pitchR;
    chX[0] = srcX; chY[0] = srcY;
    chX[1] = dstX; chY[1] = dstY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirR   <= '0;
      pitchR <= '0;
    end else if (strb.load) begin
      dirR   <= dir;
      pitchR <= pitchNow;
    end
  end

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    blit_chan #(
      .COORD_W(COORD_W), .BPP_W(BPP_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
    ) u_chan (
      .clk(clk), .rstN(rstN), .strb(strb),
      .posX(chX[g]), .posY(chY[g]), .width(width), .height(height), .bpp(bpp),
      .pitch(pitchNow), .decX(dirNow[0]), .decY(dirNow[1]),
      .addr(chAddr[g])
    );
  end

  assign srcAddr = chAddr[0];
  assign dstAddr = chAddr[1];
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl import blit_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int BPP_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [BPP_W-1:0]   bpp,
  output blitStrobe_t        strb,
  output logic               addrValid,
  output logic               done
);
  localparam int SPAN_W = COORD_W + BPP_W;

  blitState_t        state;
  logic [SPAN_W-1:0] spanBytes, spanM1, xCnt, xReload;
  logic [COORD_W-1:0] yCnt;
  logic              zeroSize, accept, running, lastCol, lastRow;

  always_comb begin
    spanBytes = {{BPP_W{1'b0}}, width} * {{COORD_W{1'b0}}, bpp};
    spanM1    = spanBytes - SPAN_W'(1);
    zeroSize  = (width == '0) || (height == '0) || (bpp == '0);
    running   = (state == ST_RUN);
    accept    = start && !running;
    lastCol   = (xCnt == '0);
    lastRow   = (yCnt == '0);
    strb.load    = accept && !zeroSize;
    strb.stepCol = running && !lastCol;
    strb.stepRow = running && lastCol && !lastRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      xCnt    <= '0;
      xReload <= '0;
      yCnt    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (zeroSize) begin
          done <= 1'b1;
        end else begin
          state   <= ST_RUN;
          xCnt    <= spanM1;
          xReload <= spanM1;
          yCnt    <= height - COORD_W'(1);
        end
      end else if (running) begin
        if (!lastCol) begin
          xCnt <= xCnt - SPAN_W'(1);
        end else if (!lastRow) begin
          xCnt <= xReload;
          yCnt <= yCnt - COORD_W'(1);
        end else begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign addrValid = running;
endmodule

// File: rtl/blitAddrGen.sv
module blitAddrGen import blit_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int BPP_W   = 3,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] srcX,
  input  logic [COORD_W-1:0] srcY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [BPP_W-1:0]   bpp,
  input  logic [PITCH_W-1:0] pitchM1,
  input  logic [1:0]         dir,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr,
  output logic               done
);
  blitStrobe_t strb;

  blit_ctrl #(.COORD_W(COORD_W), .BPP_W(BPP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .width(width), .height(height), .bpp(bpp),
    .strb(strb), .addrValid(addrValid), .done(done)
  );

  blit_dp #(
    .COORD_W(COORD_W), .BPP_W(BPP_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcX(srcX), .srcY(srcY), .dstX(dstX), .dstY(dstY),
    .width(width), .height(height), .bpp(bpp),
    .pitchM1(pitchM1), .dir(dir),
    .srcAddr(srcAddr), .dstAddr(dstAddr)
  );
endmodule

// File: rtl/blitAddrGen_chk.sv
module blitAddrGen_chk #(
  parameter int COORD_W = 12,
  parameter int BPP_W   = 3,
  parameter int ADDR_W  = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [COORD_W-1:0] width,
  input logic [COORD_W-1:0] height,
  input logic [BPP_W-1:0]   bpp,
  input logic               addrValid,
  input logic [ADDR_W-1:0]  srcAddr,
  input logic [ADDR_W-1:0]  dstAddr,
  input logic               done
);
  AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(done && addrValid)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_STREAM_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> (addrValid || done)); // R7

  AST_ZERO_SIZE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !addrValid && ((width == '0) || (height == '0) || (bpp == '0)))
      |=> (done && !addrValid)); // R9

  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && $past(addrValid))
      |-> ((srcAddr - $past(srcAddr)) == (dstAddr - $past(dstAddr)))); // R11

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && start && !done) |=> (addrValid || done)); // R10
endmodule

bind blitAddrGen blitAddrGen_chk #(
  .COORD_W(COORD_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .width(width), .height(height), .bpp(bpp),
  .addrValid(addrValid), .srcAddr(srcAddr), .dstAddr(dstAddr), .done(done)
);

// File: tb/blitAddrGen_bench.sv
module blitAddrGen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COORD_W = 12;
  localparam int BPP_W   = 3;
  localparam int PITCH_W = 14;
  localparam int ADDR_W  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COORD_W-1:0] srcX = '0, srcY = '0, dstX = '0, dstY = '0;
  logic [COORD_W-1:0] width = '0, height = '0;
  logic [BPP_W-1:0]   bpp = '0;
  logic [PITCH_W-1:0] pitchM1 = '0;
  logic [1:0]         dir = '0;
  logic               addrValid, done;
  logic [ADDR_W-1:0]  srcAddr, dstAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  blitAddrGen #(.COORD_W(COORD_W), .BPP_W(BPP_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W))
  u_blitAddrGen (
    .clk(clk), .rstN(rstN), .start(start),
    .srcX(srcX), .srcY(srcY), .dstX(dstX), .dstY(dstY),
    .width(width), .height(height), .bpp(bpp), .pitchM1(pitchM1), .dir(dir),
    .addrValid(addrValid), .srcAddr(srcAddr), .dstAddr(dstAddr), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;
  bit zeroMode = 0;
  bit prevValid = 0;
  string curReq = "R2";
  logic [ADDR_W-1:0] expSrc[$];
  logic [ADDR_W-1:0] expDst[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int addrOf(int x, int y, int w, int h, int b, int p,
                                logic [1:0] d, int r, int c);
    int rowY, xb;
    rowY = d[1] ? (y + h - 1 - r) : (y + r);
    xb   = d[0] ? (x * b + w * b - 1 - c) : (x * b + c);
    return rowY * p + xb;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (addrValid) begin
        if (expSrc.size() == 0) begin
          check(0, curReq, "unexpected pair, queue depth", 0, 0);
        end else begin
          logic [ADDR_W-1:0] es, ed;
          es = expSrc.pop_front();
          ed = expDst.pop_front();
          check(srcAddr == es, curReq, "srcAddr", srcAddr, es);
          check(dstAddr == ed, curReq, "dstAddr", dstAddr, ed);
        end
      end
      if (done) begin
        check(expSrc.size() == 0, "R7", "pairs missing at done", expSrc.size(), 0);
        if (!zeroMode)
          check(prevValid, "R8", "done right after last pair", prevValid, 1);
      end
      prevValid = addrValid;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runBlit(input string req, input int sx, input int sy,
                         input int dx, input int dy, input int w, input int h,
                         input int b, input int p, input logic [1:0] d,
                         input bit disturb);
    int guard;
    curReq = req;
    zeroMode = (w == 0 || h == 0 || b == 0);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w * b; c++) begin
        expSrc.push_back(ADDR_W'(addrOf(sx, sy, w, h, b, p, d, r, c)));
        expDst.push_back(ADDR_W'(addrOf(dx, dy, w, h, b, p, d, r, c)));
      end
    @(negedge clk);
    srcX = COORD_W'(sx); srcY = COORD_W'(sy); dstX = COORD_W'(dx); dstY = COORD_W'(dy);
    width = COORD_W'(w); height = COORD_W'(h); bpp = BPP_W'(b);
    pitchM1 = PITCH_W'(p - 1); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (zeroMode) check(done === 1'b1, req, "done one cycle after start", done, 1);
    if (disturb) begin
      @(negedge clk);
      srcX = 7; dstY = 9; width = 5; height = 1; bpp = 1; pitchM1 = 15; dir = 2'b11;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(done === 1'b1, req, "done seen", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R8", "done single cycle", done, 0);
    check(addrValid === 1'b0, req, "idle after done", addrValid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(addrValid === 1'b0, "R1", "addrValid in reset", addrValid, 0);
    check(done === 1'b0, "R1", "done in reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(addrValid === 1'b0 && done === 1'b0, "R1", "idle after reset", addrValid, 0);

    // R2 R6 R5: ascending both ways, one byte per pixel, pitch 64
    runBlit("R2", 3, 2, 10, 5, 4, 3, 1, 64, 2'b00, 0);
    // R3: right-to-left with two bytes per pixel
    runBlit("R3", 5, 1, 2, 4, 3, 2, 2, 40, 2'b01, 0);
    // R4: bottom-to-top with three bytes per pixel
    runBlit("R4", 1, 3, 6, 0, 2, 3, 3, 50, 2'b10, 0);
    // R3 and R4 combined, overlapping rectangles
    runBlit("R4", 2, 2, 3, 3, 2, 2, 4, 32, 2'b11, 0);
    // R6: single pixel, wide pitch
    runBlit("R6", 9, 9, 0, 0, 1, 1, 1, 1000, 2'b11, 0);
    // R7: long row to exercise counter span
    runBlit("R7", 0, 0, 20, 1, 30, 2, 2, 128, 2'b01, 0);
    // R9: each zero dimension
    runBlit("R9", 1, 1, 2, 2, 0, 4, 1, 16, 2'b00, 0);
    runBlit("R9", 1, 1, 2, 2, 4, 0, 1, 16, 2'b00, 0);
    runBlit("R9", 1, 1, 2, 2, 4, 4, 0, 16, 2'b00, 0);
    // R10: second start mid stream with altered inputs is ignored
    runBlit("R10", 4, 6, 1, 2, 3, 3, 2, 24, 2'b10, 1);
    // R11 checked in every pair above; R5 with pitch exactly equal to row span
    runBlit("R5", 0, 1, 0, 3, 4, 3, 1, 4, 2'b00, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule